// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block sits between a host that issues configuration-space requests of one, two or four bytes and a bridge register bank that only handles aligned 32-bit configuration accesses. The bank is reached through a pair of 64-bit indirect registers: a read register and a write register. The block carries one request at a time. It converts each request into the sequence of 64-bit register accesses the bank needs, and it returns a response that carries a done pulse, read data and a status bit.

A read goes in two steps. First the aligned dword address is stored into the read register. Then that same register is loaded, and the configuration data arrives in its upper half. Before the requested lanes are extracted, a fixed set of dwords is patched or replaced. This hides broken capability fields and presents a synthesized allocation entry whose three data words come from input pins. A byte or halfword write becomes a read-modify-write of the containing dword. Status bits that clear when written with one, and that lie outside the target lanes, are forced to zero so that the widened write cannot clear them by accident. Requests to a nonzero function, or at offsets of 2048 and above, are rejected without any register access.

Top module: `cfgx_bridge`

## Requirements
- R1: After reset, req_ready is 1, rsp_done is 0 and ind_req is 0.
- R2: A request with req_func not equal to 0, or with req_off of 2048 or more, completes with rsp_status = 1 and makes no indirect access. For a rejected read, rsp_rdata is 0xFFFFFFFF. For a rejected write, the configuration contents stay unchanged.
- R3: An accepted read makes exactly two indirect accesses. The first is a store (ind_we = 1) to the read register (ind_sel = 0) with ind_wdata = {32'h0, dword address}, where the dword address is req_off with bits 1:0 cleared. The second is a load (ind_we = 0) of the read register, and the dword is taken from ind_rdata[63:32]. Each access holds ind_req, ind_sel, ind_we and ind_wdata steady until ind_ack.
- R4: Read data is the (patched) dword shifted right by 8*req_off[1:0]. It is then masked to 0xFF for size code 0 (byte) or to 0xFFFF for size code 1 (halfword). Size codes 2 and 3 return the shifted dword unmasked.
- R5: Before extraction, read dwords are patched by dword offset. 0x40 becomes (d & 0xFFFF00FF) | 0x7000. 0x70 becomes d | 0x04000000. 0xB0 becomes (d & 0xC00000FF) | 0x0003BC00. 0xB4 and 0xC0 read as 0. 0xB8 reads as 0x000F0000. 0xBC reads as 0x00010014. 0xC4 reads as 0x80FF0003.
- R6: Dword offsets 0xC8, 0xCC and 0xD0 read as ea_word0, ea_word1 and ea_word2 respectively.
- R7: An accepted word write (size code 2 or 3) makes exactly one indirect access: a store to the write register (ind_sel = 1, ind_we = 1) with ind_wdata = {write data, dword address}. No bit of the data is masked.
- R8: An accepted byte or halfword write makes three indirect accesses. It reads the containing dword as in R3, without any R5/R6 patching. It then clears the target lanes, ORs in the new lane data shifted by 8*req_off[1:0], and stores the merged dword as in R7.
- R9: In a byte or halfword write, bits that lie outside the target lanes and inside the offset's write-one-to-clear mask are stored as 0. The masks are: 0x04 and 0x1C use 0xFF000000; 0x44 uses 0xFFFFFE00; 0x78, 0x80, 0x88, 0x90 and 0xA0 use 0xFFFF0000; 0x104, 0x110, 0x130 and 0x160 use 0xFFFFFFFF; all other offsets use 0.
- R10: req_ready is 0 from the cycle after a request is accepted until the request's response has completed, and it is 1 otherwise. Accepted requests that are not rejected complete with rsp_status = 0.
- R11: Every accepted request produces exactly one rsp_done pulse, one cycle long, with rsp_rdata and rsp_status valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_func | input | 3 | Function number; only 0 is served |
| req_off | input | 12 | Byte offset in configuration space |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result (0 for writes) |
| rsp_status | output | 1 | 0 success, 1 not found |
| ea_word0 | input | 32 | Allocation entry word returned at 0xC8 |
| ea_word1 | input | 32 | Allocation entry word returned at 0xCC |
| ea_word2 | input | 32 | Allocation entry word returned at 0xD0 |
| ind_req | output | 1 | Indirect register access request |
| ind_sel | output | 1 | 0 read register, 1 write register |
| ind_we | output | 1 | 1 store, 0 load |
| ind_wdata | output | 64 | Store data |
| ind_ack | input | 1 | Access acknowledge |
| ind_rdata | input | 64 | Load data, valid with ind_ack |

## Verification
The hardest case to reach is a widened write that meets a write-one-to-clear status dword. It only shows up when the stored dword already has ones in protected bits outside the target lanes, so the bench's register model preloads those dwords with all ones. It then issues byte and halfword writes at lanes both inside and outside the protected field, and compares the stored dword bit for bit. A second subtle case is a sub-word write at an offset that also has a read patch. Here the merge must use the raw dword and not the patched one, and the bench checks this by writing a byte at offset 0x41 and inspecting the stored result.

// File: rtl/cfgx_pkg.sv
// Shared types and encodings for the indirect configuration bridge.
// Assumes 32-bit configuration dwords carried in the upper half of a
// 64-bit indirect register.
package cfgx_pkg;
    localparam int DATA_W = 32;
    localparam int IND_W  = 2 * DATA_W;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    localparam logic SEL_RDREG = 1'b0;
    localparam logic SEL_WRREG = 1'b1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RADDR,
        ST_RLOAD,
        ST_WSTORE,
        ST_DONE
    } cfgx_state_e;
endpackage

// File: rtl/cfgx_lanes.sv
// Lane selection for a configuration request: the unshifted lane mask
// chosen by size code, the shift amount from the byte offset, and the
// mask moved to its byte lanes. Assumes size codes 2 and 3 mean a dword.
module cfgx_lanes
    import cfgx_pkg::*;
(
    input  logic [1:0]        lane,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] lane_mask,
    output logic [DATA_W-1:0] sh_mask,
    output logic [4:0]        shamt
);
    // Pick the lane mask and place it at the addressed byte.
    always_comb begin
        case (size)
            SZ_BYTE: lane_mask = 32'h0000_00FF;
            SZ_HALF: lane_mask = 32'h0000_FFFF;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
        shamt   = {lane, 3'b000};
        sh_mask = lane_mask << shamt;
    end
endmodule

// File: rtl/cfgx_fixup.sv
// Read-side patch table. It replaces or edits returned dwords at fixed
// dword offsets and presents the three allocation entry words. Assumes
// dw_off has bits 1:0 clear.
module cfgx_fixup
    import cfgx_pkg::*;
#(
    parameter int OFF_W = 12
) (
    input  logic [OFF_W-1:0]  dw_off,
    input  logic [DATA_W-1:0] raw,
    input  logic [DATA_W-1:0] ea0,
    input  logic [DATA_W-1:0] ea1,
    input  logic [DATA_W-1:0] ea2,
    output logic [DATA_W-1:0] fixed
);
    logic [31:0] key;
    assign key = 32'(dw_off);

    // Apply the per-offset patch; other offsets pass through.
    always_comb begin
        case (key)
            32'h40:  fixed = (raw & 32'hFFFF_00FF) | 32'h0000_7000;
            32'h70:  fixed = raw | (32'd2 << 25);
            32'hB0:  fixed = (raw & 32'hC000_00FF) | 32'h0003_BC00;
            32'hB4:  fixed = 32'h0;
            32'hB8:  fixed = 32'h000F_0000;
            32'hBC:  fixed = 32'h0001_0014;
            32'hC0:  fixed = 32'h0;
            32'hC4:  fixed = 32'h80FF_0003;
            32'hC8:  fixed = ea0;
            32'hCC:  fixed = ea1;
            32'hD0:  fixed = ea2;
            default: fixed = raw;
        endcase
    end
endmodule

// File: rtl/cfgx_w1c.sv
// Write-one-to-clear mask lookup by dword offset. It is used only when a
// sub-word write is widened to a dword. Assumes dw_off has bits 1:0 clear.
module cfgx_w1c
    import cfgx_pkg::*;
#(
    parameter int OFF_W = 12
) (
    input  logic [OFF_W-1:0]  dw_off,
    output logic [DATA_W-1:0] w1c
);
    logic [31:0] key;
    assign key = 32'(dw_off);

    // Map the dword offset to its protected status bits.
    always_comb begin
        case (key)
            32'h04, 32'h1C:                          w1c = 32'hFF00_0000;
            32'h44:                                  w1c = 32'hFFFF_FE00;
            32'h78, 32'h80, 32'h88, 32'h90, 32'hA0:  w1c = 32'hFFFF_0000;
            32'h104, 32'h110, 32'h130, 32'h160:      w1c = 32'hFFFF_FFFF;
            default:                                 w1c = 32'h0;
        endcase
    end
endmodule

// File: rtl/cfgx_bridge.sv
// Indirect configuration access bridge (top). It accepts one host request
// at a time and runs it as a sequence of 64-bit indirect register accesses:
// an address store and a load for reads, one store for dword writes, and a
// store, a load and a store for sub-word writes. It patches read data and
// protects status bits during widened writes. Assumes the indirect target
// returns load data together with ind_ack and that each access is held
// until it is acknowledged.
module cfgx_bridge
    import cfgx_pkg::*;
#(
    parameter int FUNC_W    = 3,
    parameter int OFF_W     = 12,
    parameter int CFG_LIMIT = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_status,
    input  logic [DATA_W-1:0] ea_word0,
    input  logic [DATA_W-1:0] ea_word1,
    input  logic [DATA_W-1:0] ea_word2,
    output logic              ind_req,
    output logic              ind_sel,
    output logic              ind_we,
    output logic [IND_W-1:0]  ind_wdata,
    input  logic              ind_ack,
    input  logic [IND_W-1:0]  ind_rdata
);
    localparam int ADDR_W = IND_W - DATA_W;

    cfgx_state_e       state;
    logic              r_write;
    logic [OFF_W-1:0]  r_off;
    logic [1:0]        r_size;
    logic [DATA_W-1:0] r_wdata;
    logic [DATA_W-1:0] wbuf;

    logic              accept, bad, is_word;
    logic [OFF_W-1:0]  dw_off;
    logic [ADDR_W-1:0] dw_addr;
    logic [DATA_W-1:0] raw, fixed, w1c, lane_mask, sh_mask;
    logic [DATA_W-1:0] rd_lanes, merged, wr_value;
    logic [4:0]        shamt;

    // Request decode on the host side.
    always_comb begin
        accept  = req_valid && req_ready;
        bad     = (req_func != '0) || (32'(req_off) >= CFG_LIMIT);
        is_word = req_size[1];
    end

    // Dword address and raw load data of the request in flight.
    always_comb begin
        dw_off  = {r_off[OFF_W-1:2], 2'b00};
        dw_addr = ADDR_W'(dw_off);
        raw     = ind_rdata[IND_W-1:DATA_W];
    end

    cfgx_lanes u_lanes (
        .lane      (r_off[1:0]),
        .size      (r_size),
        .lane_mask (lane_mask),
        .sh_mask   (sh_mask),
        .shamt     (shamt)
    );

    cfgx_fixup #(.OFF_W(OFF_W)) u_fix (
        .dw_off (dw_off),
        .raw    (raw),
        .ea0    (ea_word0),
        .ea1    (ea_word1),
        .ea2    (ea_word2),
        .fixed  (fixed)
    );

    cfgx_w1c #(.OFF_W(OFF_W)) u_w1c (
        .dw_off (dw_off),
        .w1c    (w1c)
    );

    // Read extraction and write merge with status-bit protection.
    always_comb begin
        rd_lanes = (fixed >> shamt) & lane_mask;
        merged   = (raw & ~sh_mask) | ((r_wdata & lane_mask) << shamt);
        wr_value = merged & ~(~sh_mask & w1c);
    end

    // Indirect port drive, derived from the current state.
    always_comb begin
        ind_req   = (state == ST_RADDR) || (state == ST_RLOAD) || (state == ST_WSTORE);
        ind_sel   = (state == ST_WSTORE) ? SEL_WRREG : SEL_RDREG;
        ind_we    = (state != ST_RLOAD);
        ind_wdata = (state == ST_WSTORE) ? {wbuf, dw_addr} : {{DATA_W{1'b0}}, dw_addr};
        req_ready = (state == ST_IDLE);
        rsp_done  = (state == ST_DONE);
    end

    // Request sequencer with captured request and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            r_write    <= 1'b0;
            r_off      <= '0;
            r_size     <= '0;
            r_wdata    <= '0;
            wbuf       <= '0;
            rsp_rdata  <= '0;
            rsp_status <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    r_write    <= req_write;
                    r_off      <= req_off;
                    r_size     <= req_size;
                    r_wdata    <= req_wdata;
                    rsp_status <= bad;
                    rsp_rdata  <= (bad && !req_write) ? '1 : '0;
                    wbuf       <= req_wdata;
                    if (bad)
                        state <= ST_DONE;
                    else if (req_write && is_word)
                        state <= ST_WSTORE;
                    else
                        state <= ST_RADDR;
                end
                ST_RADDR: if (ind_ack) state <= ST_RLOAD;
                ST_RLOAD: if (ind_ack) begin
                    if (r_write) begin
                        wbuf  <= wr_value;
                        state <= ST_WSTORE;
                    end else begin
                        rsp_rdata <= rd_lanes;
                        state     <= ST_DONE;
                    end
                end
                ST_WSTORE: if (ind_ack) state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfgx_bridge_chk.sv
// Protocol checker for cfgx_bridge, attached by bind. It watches the host
// handshake, the response pulse and the indirect access handshake.
module cfgx_bridge_chk #(
    parameter int FUNC_W    = 3,
    parameter int OFF_W     = 12,
    parameter int CFG_LIMIT = 2048
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [FUNC_W-1:0] req_func,
    input logic [OFF_W-1:0]  req_off,
    input logic              rsp_done,
    input logic              ind_req,
    input logic              ind_sel,
    input logic              ind_we,
    input logic [63:0]       ind_wdata,
    input logic              ind_ack
);
    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_req || rsp_done) |-> !req_ready);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R3
    access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_req && !ind_ack) |=> (ind_req && $stable(ind_sel) && $stable(ind_we) && $stable(ind_wdata)));

    // R2
    reject_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ((req_func != '0) || (32'(req_off) >= CFG_LIMIT))) |=> (!ind_req && rsp_done));

    // R7
    write_reg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_req && ind_sel) |-> ind_we);

    // R3
    dword_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_req && ind_we) |-> (ind_wdata[1:0] == 2'b00));
endmodule

bind cfgx_bridge cfgx_bridge_chk #(
    .FUNC_W(FUNC_W), .OFF_W(OFF_W), .CFG_LIMIT(CFG_LIMIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_func  (req_func),
    .req_off   (req_off),
    .rsp_done  (rsp_done),
    .ind_req   (ind_req),
    .ind_sel   (ind_sel),
    .ind_we    (ind_we),
    .ind_wdata (ind_wdata),
    .ind_ack   (ind_ack)
);

// File: tb/sim_cfgx_bridge.sv
// Scoreboard bench for cfgx_bridge with a behavioural indirect register model.
module sim_cfgx_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_func = '0;
    logic [11:0] req_off = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_done, rsp_status;
    logic [31:0] rsp_rdata;
    logic        ind_req, ind_sel, ind_we, ind_ack;
    logic [63:0] ind_wdata, ind_rdata;

    localparam logic [31:0] EA0 = 32'h8C20_0002;
    localparam logic [31:0] EA1 = 32'h000F_FFFC;
    localparam logic [31:0] EA2 = 32'h0000_87E0;

    int checks = 0, fails = 0, acc_cnt = 0, acc_seen = 0;
    logic finished = 1'b0;

    always #4 clk = ~clk;

    cfgx_bridge u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_func(req_func), .req_off(req_off),
        .req_size(req_size), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .rsp_status(rsp_status), .ea_word0(EA0),
        .ea_word1(EA1), .ea_word2(EA2), .ind_req(ind_req), .ind_sel(ind_sel),
        .ind_we(ind_we), .ind_wdata(ind_wdata), .ind_ack(ind_ack),
        .ind_rdata(ind_rdata)
    );

    // Indirect register model: read-address latch, dword memory, one-cycle ack.
    logic [31:0] mem [512];
    logic [31:0] rd_lat;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= 32'h3C5A_0000 ^ (i * 32'h0101_0307);
            mem[32'h04 >> 2]  <= 32'hFFFF_FFFF;
            mem[32'h44 >> 2]  <= 32'hFFFF_FFFF;
            mem[32'h78 >> 2]  <= 32'hFFFF_FFFF;
            mem[32'h104 >> 2] <= 32'hFFFF_FFFF;
            mem[32'h40 >> 2]  <= 32'h1234_5678;
            rd_lat  <= '0;
            ind_ack <= 1'b0;
        end else begin
            ind_ack <= ind_req && !ind_ack;
            if (ind_req && ind_ack) begin
                acc_cnt <= acc_cnt + 1;
                if (ind_we && !ind_sel) rd_lat <= ind_wdata[31:0];
                if (ind_we && ind_sel)  mem[ind_wdata[10:2]] <= ind_wdata[63:32];
            end
        end
    end
    assign ind_rdata = {mem[rd_lat[10:2]], rd_lat};

    function automatic logic [31:0] exp_fix(input logic [31:0] dw, input logic [31:0] d);
        case (dw)
            32'h40:  return (d & 32'hFFFF_00FF) | 32'h7000;
            32'h70:  return d | 32'h0400_0000;
            32'hB0:  return (d & 32'hC000_00FF) | 32'h0003_BC00;
            32'hB4, 32'hC0: return 32'h0;
            32'hB8:  return 32'h000F_0000;
            32'hBC:  return 32'h0001_0014;
            32'hC4:  return 32'h80FF_0003;
            32'hC8:  return EA0;
            32'hCC:  return EA1;
            32'hD0:  return EA2;
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] exp_prot(input logic [31:0] dw);
        case (dw)
            32'h04, 32'h1C: return 32'hFF00_0000;
            32'h44: return 32'hFFFF_FE00;
            32'h78, 32'h80, 32'h88, 32'h90, 32'hA0: return 32'hFFFF_0000;
            32'h104, 32'h110, 32'h130, 32'h160: return 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    typedef struct {
        logic        st;
        logic [31:0] rd;
        int          nacc;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Monitor: pop the expected item at each response and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_done) begin
                if (exp_q.size() == 0) begin
                    check("R11 unexpected response", 1'b0, 32'(rsp_status), 32'h0);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({t, " status"}, rsp_status == e.st, 32'(rsp_status), 32'(e.st));
                    check({t, " rdata"}, rsp_rdata == e.rd, rsp_rdata, e.rd);
                    check({t, " access count"}, (acc_cnt - acc_seen) == e.nacc,
                          32'(acc_cnt - acc_seen), 32'(e.nacc));
                end
                acc_seen = acc_cnt;
            end
        end
    end

    // Driver: compute the expectation, run the handshake, wait for the response.
    task automatic do_req(input string tag, input logic wr, input logic [2:0] fn,
                          input logic [11:0] off, input logic [1:0] sz, input logic [31:0] wd);
        exp_t        e;
        logic        rej;
        logic [31:0] dw, old, nv, smask;
        logic [4:0]  sh;
        rej   = (fn != 0) || (off >= 12'd2048);
        dw    = {20'h0, off[11:2], 2'b00};
        old   = mem[dw[10:2]];
        sh    = {off[1:0], 3'b000};
        smask = size_mask(sz) << sh;
        e.st  = rej;
        if (rej) begin
            e.rd = wr ? 32'h0 : 32'hFFFF_FFFF;
            e.nacc = 0;
        end else if (!wr) begin
            e.rd = (exp_fix(dw, old) >> sh) & size_mask(sz);
            e.nacc = 2;
        end else begin
            e.rd = 32'h0;
            e.nacc = sz[1] ? 1 : 3;
        end
        if (sz[1]) nv = wd;
        else nv = ((old & ~smask) | ((wd & size_mask(sz)) << sh)) & ~(~smask & exp_prot(dw));
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_func = fn; req_off = off;
        req_size = sz; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R10 ready low while busy"}, req_ready == 1'b0, 32'(req_ready), 32'h0);
        while (!rsp_done) @(negedge clk);
        @(negedge clk);
        check({tag, " R11 done is a pulse"}, rsp_done == 1'b0, 32'(rsp_done), 32'h0);
        check({tag, " R10 ready after response"}, req_ready == 1'b1, 32'(req_ready), 32'h1);
        if (wr) begin
            logic [31:0] want;
            want = rej ? old : nv;
            check({tag, " stored dword"}, mem[dw[10:2]] == want, mem[dw[10:2]], want);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset ready", req_ready == 1'b1, 32'(req_ready), 32'h1);
        check("R1 reset done", rsp_done == 1'b0, 32'(rsp_done), 32'h0);
        check("R1 reset ind_req", ind_req == 1'b0, 32'(ind_req), 32'h0);

        do_req("R3 word read 0x00", 0, 0, 12'h000, 2'd2, 0);
        do_req("R4 byte read lane1", 0, 0, 12'h00D, 2'd0, 0);
        do_req("R4 half read lane2", 0, 0, 12'h00E, 2'd1, 0);
        do_req("R4 byte read lane3", 0, 0, 12'h013, 2'd0, 0);
        do_req("R5 patch 0x40", 0, 0, 12'h040, 2'd2, 0);
        do_req("R5 patch 0x41 byte", 0, 0, 12'h041, 2'd0, 0);
        do_req("R5 patch 0x70", 0, 0, 12'h070, 2'd2, 0);
        do_req("R5 patch 0xB0", 0, 0, 12'h0B0, 2'd2, 0);
        do_req("R5 patch 0xB4", 0, 0, 12'h0B4, 2'd2, 0);
        do_req("R5 patch 0xB8", 0, 0, 12'h0B8, 2'd2, 0);
        do_req("R5 patch 0xBC", 0, 0, 12'h0BC, 2'd2, 0);
        do_req("R5 patch 0xC0", 0, 0, 12'h0C0, 2'd2, 0);
        do_req("R5 patch 0xC6 half", 0, 0, 12'h0C6, 2'd1, 0);
        do_req("R6 entry 0xC8", 0, 0, 12'h0C8, 2'd2, 0);
        do_req("R6 entry 0xCC", 0, 0, 12'h0CC, 2'd2, 0);
        do_req("R6 entry 0xD0", 0, 0, 12'h0D0, 2'd3, 0);

        do_req("R2 read func1", 0, 3'd1, 12'h000, 2'd2, 0);
        do_req("R2 read off 0x800", 0, 0, 12'h800, 2'd2, 0);
        do_req("R2 write func2", 1, 3'd2, 12'h010, 2'd2, 32'hDEAD_BEEF);
        do_req("R2 write off 0xFFC", 1, 0, 12'hFFC, 2'd2, 32'h1111_2222);
        do_req("R2 last legal dword", 0, 0, 12'h7FC, 2'd2, 0);

        do_req("R7 word write 0x104", 1, 0, 12'h104, 2'd2, 32'h0000_00FF);
        do_req("R7 word write 0x20", 1, 0, 12'h020, 2'd3, 32'hCAFE_F00D);
        do_req("R9 byte write 0x06", 1, 0, 12'h006, 2'd0, 32'h0000_005A);
        do_req("R9 half write 0x44", 1, 0, 12'h044, 2'd1, 32'h0000_1234);
        do_req("R9 half write 0x7A target", 1, 0, 12'h07A, 2'd1, 32'h0000_00A5);
        do_req("R8 byte write 0x11", 1, 0, 12'h011, 2'd0, 32'hFFFF_FF77);
        do_req("R8 byte write 0x41 raw merge", 1, 0, 12'h041, 2'd0, 32'h0000_0099);
        do_req("R8 read back 0x10", 0, 0, 12'h010, 2'd2, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R11 actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule